// File: doc/BRIEF.md
# Exception Entry Controller

This block performs the register side of taking an exception. When `req_valid` is high on a clock edge, it reads the request: the kind, a sub-code, the PC of the faulting instruction and a flag that marks a branch delay slot. It also reads the current status, cause and debug register values and the debug-mode flag. On that same edge it registers the new status, cause and debug values, the saved return PC, and the address to fetch next. `redirect_valid` pulses for one cycle to announce that address.

There are three separate entry paths. Ordinary exceptions write the cause code and set the exception-level bit. Reset-class events (hard reset, soft reset, NMI) set the error-level bit and save the error return PC. Debug events set one debug-register bit, save the debug return PC and enter debug mode.

The PC save register depends on the path. When the faulting instruction is in a delay slot, the saved PC points at the branch before it. The exception vector depends on the bootstrap bit, the exception level, the interrupt-vector bit and the sub-code. When `req_valid` is low, every registered output holds its value.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is zero except `random_o`, which is `TLB_ENTRIES-1`.
- R2: An ordinary request sets status bit 1 (exception level) and keeps every other status bit. It writes the exception code into cause bits 6:2. The codes are: interrupt (kind 9) 0, TLB load miss (kind 10) 2, TLB store miss (kind 11) 3, coprocessor unusable (kind 12) 11, and for kind 13 or above `req_sub`. Cause bits 30, 27:7 and 1:0 are kept, and so are bits 29:28 except on kind 12. Debug register and `dm_o` are unchanged.
- R3: For ordinary requests, `epc_o` is `req_pc-4` with cause bit 31 set when `req_in_ds` is high. Otherwise `epc_o` is `req_pc` with cause bit 31 cleared.
- R4: The ordinary vector base is 0x80000000 when status bit 22 (BEV) is clear and 0xBFC00200 when it is set. The general offset is 0x180.
- R5: An interrupt (kind 9) outside debug mode uses offset 0x200 when cause bit 23 (IV) is set, and 0x180 otherwise.
- R6: A TLB miss (kind 10 or 11) with `req_sub`=1 and status bit 1 clear uses offset 0x000. With status bit 1 set, or any other sub-code, it uses 0x180.
- R7: Coprocessor unusable (kind 12) writes `req_sub[1:0]` into cause bits 29:28.
- R8: Debug kinds set one debug-register bit each: single step (3) bit 0, debug interrupt (4) bit 5, instruction break (5) bit 4, breakpoint (6) bit 1, data break store (7) bit 3, data break load (8) bit 2. They save `depc_o` by the delay-slot rule and set `dm_o`. They redirect to 0xBFC00480 and leave status, cause, `epc_o` and `errorepc_o` unchanged.
- R9: Single step (kind 3) saves `depc_o` = `req_pc` even when `req_in_ds` is high, and does not raise `bd_clr`.
- R10: An interrupt (kind 9) with `dm_i` high is taken as a debug interrupt (R8, bit 5).
- R11: Hard reset (0), soft reset (1) and NMI (2) save `errorepc_o` by the delay-slot rule and redirect to 0xBFC00000. Hard reset writes status exactly bits 28, 22 and 2. Soft reset ORs bits 28, 22, 20 and 2 into the status input, and NMI ORs bits 28, 22, 19 and 2. These three kinds leave cause, debug, `epc_o` and `depc_o` unchanged.
- R12: Only a hard reset request loads `random_o` with `TLB_ENTRIES-1` and pulses `watch_clr`.
- R13: `bd_clr` pulses when a request other than single step comes from a delay slot. Without a request, `redirect_valid`, `bd_clr` and `watch_clr` are low and all other outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request this cycle |
| req_kind | input | 4 | Request kind (encoding in R2, R8, R11) |
| req_sub | input | 5 | Sub-code: refill flag, unit number or raw code |
| req_pc | input | 32 | PC of the faulting instruction |
| req_in_ds | input | 1 | Faulting instruction is in a delay slot |
| status_i | input | 32 | Current status register |
| cause_i | input | 32 | Current cause register |
| debug_i | input | 32 | Current debug register |
| dm_i | input | 1 | Currently in debug mode |
| status_o | output | 32 | New status register |
| cause_o | output | 32 | New cause register |
| debug_o | output | 32 | New debug register |
| epc_o | output | 32 | Exception return PC |
| errorepc_o | output | 32 | Error return PC |
| depc_o | output | 32 | Debug return PC |
| random_o | output | $clog2(TLB_ENTRIES) | TLB random index |
| dm_o | output | 1 | New debug-mode flag |
| bd_clr | output | 1 | Clear the delay-slot flag |
| watch_clr | output | 1 | Clear the watch register |
| redirect_valid | output | 1 | Redirect address valid (one cycle) |
| redirect_pc | output | 32 | Next fetch address |

## Verification
The bench builds the block with `TLB_ENTRIES`=8, so `random_o` is 3 bits wide and its reload value 7 differs from zero.

The bench sweeps every request kind against every combination of:
- the delay-slot flag,
- the BEV, exception-level and IV bits,
- the debug-mode flag,
- five sub-codes.

That sweep reaches every vector offset, every debug bit, and the interrupt-to-debug conversion. It also reaches the single-step exception to the delay-slot rule. An idle cycle follows each request to show that the outputs hold.

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl #(
  parameter int          TLB_ENTRIES = 16,
  parameter logic [31:0] NORM_BASE   = 32'h8000_0000,
  parameter logic [31:0] BOOT_BASE   = 32'hBFC0_0200,
  parameter logic [31:0] RESET_VEC   = 32'hBFC0_0000,
  parameter logic [31:0] DEBUG_VEC   = 32'hBFC0_0480
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           req_valid,
  input  logic [3:0]                     req_kind,
  input  logic [4:0]                     req_sub,
  input  logic [31:0]                    req_pc,
  input  logic                           req_in_ds,
  input  logic [31:0]                    status_i,
  input  logic [31:0]                    cause_i,
  input  logic [31:0]                    debug_i,
  input  logic                           dm_i,
  output logic [31:0]                    status_o,
  output logic [31:0]                    cause_o,
  output logic [31:0]                    debug_o,
  output logic [31:0]                    epc_o,
  output logic [31:0]                    errorepc_o,
  output logic [31:0]                    depc_o,
  output logic [$clog2(TLB_ENTRIES)-1:0] random_o,
  output logic                           dm_o,
  output logic                           bd_clr,
  output logic                           watch_clr,
  output logic                           redirect_valid,
  output logic [31:0]                    redirect_pc
);
  localparam int RW = $clog2(TLB_ENTRIES);
  localparam logic [RW-1:0] RAND_INIT = RW'(TLB_ENTRIES - 1);

  localparam logic [3:0] K_RESET = 4'd0, K_SOFT = 4'd1, K_NMI = 4'd2;
  localparam logic [3:0] K_DSS = 4'd3, K_DINT = 4'd4, K_DIB = 4'd5;
  localparam logic [3:0] K_DBP = 4'd6, K_DDBS = 4'd7, K_DDBL = 4'd8;
  localparam logic [3:0] K_INT = 4'd9, K_TLBL = 4'd10, K_TLBS = 4'd11, K_CPU = 4'd12;

  localparam int ST_EXL = 1, ST_ERL = 2, ST_NMI = 19, ST_SR = 20, ST_BEV = 22, ST_CU0 = 28;
  localparam int CA_IV = 23, CA_BD = 31;

  wire is_err  = req_kind <= K_NMI;
  wire int_dbg = (req_kind == K_INT) && dm_i;
  wire is_dbg  = ((req_kind >= K_DSS) && (req_kind <= K_DDBL)) || int_dbg;
  wire is_tlb  = (req_kind == K_TLBL) || (req_kind == K_TLBS);
  wire use_ds  = req_in_ds && (req_kind != K_DSS);

  wire [31:0] ret_pc = use_ds ? req_pc - 32'd4 : req_pc;

  logic [4:0]  exc_code;
  logic [4:0]  dbg_bit;
  logic [31:0] vec_off;
  logic [31:0] new_cause;
  logic [31:0] err_status;

  always_comb begin
    case (req_kind)
      K_INT:   exc_code = 5'd0;
      K_TLBL:  exc_code = 5'd2;
      K_TLBS:  exc_code = 5'd3;
      K_CPU:   exc_code = 5'd11;
      default: exc_code = req_sub;
    endcase
  end

  always_comb begin
    case (req_kind)
      K_DSS:   dbg_bit = 5'd0;
      K_DBP:   dbg_bit = 5'd1;
      K_DDBL:  dbg_bit = 5'd2;
      K_DDBS:  dbg_bit = 5'd3;
      K_DIB:   dbg_bit = 5'd4;
      default: dbg_bit = 5'd5;
    endcase
  end

  always_comb begin
    if (is_tlb && req_sub == 5'd1 && !status_i[ST_EXL])
      vec_off = 32'h0000_0000;
    else if (req_kind == K_INT && cause_i[CA_IV])
      vec_off = 32'h0000_0200;
    else
      vec_off = 32'h0000_0180;
  end

  always_comb begin
    new_cause        = cause_i;
    new_cause[CA_BD] = req_in_ds;
    new_cause[6:2]   = exc_code;
    if (req_kind == K_CPU) new_cause[29:28] = req_sub[1:0];
  end

  always_comb begin
    err_status         = status_i;
    err_status[ST_CU0] = 1'b1;
    err_status[ST_BEV] = 1'b1;
    err_status[ST_ERL] = 1'b1;
    case (req_kind)
      K_RESET: err_status = (32'd1 << ST_CU0) | (32'd1 << ST_BEV) | (32'd1 << ST_ERL);
      K_SOFT:  err_status[ST_SR]  = 1'b1;
      default: err_status[ST_NMI] = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o       <= '0;
      cause_o        <= '0;
      debug_o        <= '0;
      epc_o          <= '0;
      errorepc_o     <= '0;
      depc_o         <= '0;
      random_o       <= RAND_INIT;
      dm_o           <= 1'b0;
      bd_clr         <= 1'b0;
      watch_clr      <= 1'b0;
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
    end else if (req_valid) begin
      redirect_valid <= 1'b1;
      bd_clr         <= use_ds;
      watch_clr      <= 1'b0;
      debug_o        <= debug_i;
      status_o       <= status_i;
      cause_o        <= cause_i;
      dm_o           <= dm_i;
      if (is_err) begin
        errorepc_o  <= ret_pc;
        status_o    <= err_status;
        redirect_pc <= RESET_VEC;
        if (req_kind == K_RESET) begin
          random_o  <= RAND_INIT;
          watch_clr <= 1'b1;
        end
      end else if (is_dbg) begin
        depc_o           <= ret_pc;
        debug_o[dbg_bit] <= 1'b1;
        dm_o             <= 1'b1;
        redirect_pc      <= DEBUG_VEC;
      end else begin
        epc_o            <= ret_pc;
        cause_o          <= new_cause;
        status_o[ST_EXL] <= 1'b1;
        redirect_pc      <= (status_i[ST_BEV] ? BOOT_BASE : NORM_BASE) + vec_off;
      end
    end else begin
      redirect_valid <= 1'b0;
      bd_clr         <= 1'b0;
      watch_clr      <= 1'b0;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk #(
  parameter int TLB_ENTRIES = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           req_valid,
  input logic [3:0]                     req_kind,
  input logic [31:0]                    req_pc,
  input logic                           req_in_ds,
  input logic                           dm_i,
  input logic [31:0]                    status_o,
  input logic [31:0]                    cause_o,
  input logic [31:0]                    epc_o,
  input logic [31:0]                    errorepc_o,
  input logic [31:0]                    depc_o,
  input logic [$clog2(TLB_ENTRIES)-1:0] random_o,
  input logic                           dm_o,
  input logic                           watch_clr,
  input logic                           redirect_valid,
  input logic [31:0]                    redirect_pc
);
  localparam int RW = $clog2(TLB_ENTRIES);

  p_exl_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 4'd10) |=> (status_o[1] && cause_o[6:2] == 5'd2));

  p_bd_epc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 4'd13 && req_in_ds) |=> (cause_o[31] && epc_o == $past(req_pc) - 32'd4));

  p_debug_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind >= 4'd4 && req_kind <= 4'd8) |=> (dm_o && redirect_pc == 32'hBFC0_0480));

  p_step_pc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 4'd3) |=> (depc_o == $past(req_pc)));

  p_int_in_dm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 4'd9 && dm_i) |=> (dm_o && $stable(epc_o)));

  p_reset_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 4'd0) |=> (status_o[2] && redirect_pc == 32'hBFC0_0000));

  p_random_reload_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 4'd0) |=> (watch_clr && random_o == RW'(TLB_ENTRIES - 1)));

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!redirect_valid && !watch_clr && $stable(epc_o) && $stable(errorepc_o) && $stable(depc_o)));
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.TLB_ENTRIES(TLB_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_pc(req_pc), .req_in_ds(req_in_ds), .dm_i(dm_i), .status_o(status_o),
  .cause_o(cause_o), .epc_o(epc_o), .errorepc_o(errorepc_o), .depc_o(depc_o),
  .random_o(random_o), .dm_o(dm_o), .watch_clr(watch_clr),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  localparam int N  = 8;
  localparam int RW = $clog2(N);

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_in_ds, dm_i;
  logic [3:0] req_kind;
  logic [4:0] req_sub;
  logic [31:0] req_pc, status_i, cause_i, debug_i;
  logic [31:0] status_o, cause_o, debug_o, epc_o, errorepc_o, depc_o, redirect_pc;
  logic [RW-1:0] random_o;
  logic dm_o, bd_clr, watch_clr, redirect_valid;

  exc_entry_ctrl #(.TLB_ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_sub(req_sub), .req_pc(req_pc), .req_in_ds(req_in_ds),
    .status_i(status_i), .cause_i(cause_i), .debug_i(debug_i), .dm_i(dm_i),
    .status_o(status_o), .cause_o(cause_o), .debug_o(debug_o), .epc_o(epc_o),
    .errorepc_o(errorepc_o), .depc_o(depc_o), .random_o(random_o), .dm_o(dm_o),
    .bd_clr(bd_clr), .watch_clr(watch_clr), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // model of held registers
  logic [31:0] m_epc = 0, m_eepc = 0, m_depc = 0;
  logic [RW-1:0] m_rand = RW'(N - 1);

  task automatic one_req(input logic [3:0] k, input logic [4:0] s, input logic [31:0] pc,
                         input logic ds, input logic bev, input logic exl, input logic iv,
                         input logic dm);
    logic [31:0] st, ca, db, e_st, e_ca, e_db, e_vec, rpc;
    logic e_dm, e_bd, e_wc, err, dbg, stp;
    logic [4:0] code;
    int bitn;
    st = 32'h0000_FF00 | (32'(bev) << 22) | (32'(exl) << 1);
    ca = 32'h4100_0003 | (32'(iv) << 23) | (32'(~ds) << 31);
    db = 32'h4000_0000;
    @(negedge clk);
    req_valid = 1; req_kind = k; req_sub = s; req_pc = pc; req_in_ds = ds;
    status_i = st; cause_i = ca; debug_i = db; dm_i = dm;
    err = (k <= 2);
    dbg = (k >= 3 && k <= 8) || (k == 9 && dm);
    stp = (k == 3);
    rpc = (ds && !stp) ? pc - 32'd4 : pc;
    e_st = st; e_ca = ca; e_db = db; e_dm = dm; e_wc = 0;
    e_bd = ds && !stp;
    if (err) begin
      // R11
      m_eepc = rpc; e_vec = 32'hBFC0_0000;
      if (k == 0) begin
        e_st = 32'h1040_0004; m_rand = RW'(N - 1); e_wc = 1;
      end else if (k == 1) e_st = st | 32'h1050_0004;
      else e_st = st | 32'h1048_0004;
    end else if (dbg) begin
      // R8 R9 R10
      case (k)
        3: bitn = 0; 6: bitn = 1; 8: bitn = 2; 7: bitn = 3; 5: bitn = 4; default: bitn = 5;
      endcase
      e_db = db | (32'd1 << bitn); m_depc = rpc; e_dm = 1; e_vec = 32'hBFC0_0480;
    end else begin
      // R2 R3 R4 R5 R6 R7
      case (k)
        9: code = 0; 10: code = 2; 11: code = 3; 12: code = 11; default: code = s;
      endcase
      e_st = st | 32'h2;
      e_ca = ca; e_ca[31] = ds; e_ca[6:2] = code;
      if (k == 12) e_ca[29:28] = s[1:0];
      m_epc = rpc;
      e_vec = (bev ? 32'hBFC0_0200 : 32'h8000_0000) +
              (((k == 10 || k == 11) && s == 1 && !exl) ? 32'h0 :
               (k == 9 && iv) ? 32'h200 : 32'h180);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(err ? "R11 status" : dbg ? "R8 status" : "R2 status", status_o, e_st);
    chk(dbg ? "R8 cause" : k == 12 ? "R7 cause" : "R2/R3 cause", cause_o, e_ca);
    chk(dbg ? (k == 9 ? "R10 debug" : "R8 debug") : "R2 debug", debug_o, e_db);
    chk("R3 epc", epc_o, m_epc);
    chk("R11 errorepc", errorepc_o, m_eepc);
    chk(stp ? "R9 depc" : "R8 depc", depc_o, m_depc);
    chk("R12 random", 32'(random_o), 32'(m_rand));
    chk("R12 watch_clr", 32'(watch_clr), 32'(e_wc));
    chk(stp ? "R9 bd_clr" : "R13 bd_clr", 32'(bd_clr), 32'(e_bd));
    chk("R8 dm", 32'(dm_o), 32'(e_dm));
    chk("R13 redirect_valid", 32'(redirect_valid), 32'd1);
    chk((k == 9) ? "R5 vector" : (k == 10 || k == 11) ? "R6 vector" : "R4 vector", redirect_pc, e_vec);
    // R13: idle cycle holds
    @(posedge clk);
    @(negedge clk);
    chk("R13 idle valid", 32'(redirect_valid), 32'd0);
    chk("R13 idle bd_clr", 32'(bd_clr), 32'd0);
    chk("R13 idle watch", 32'(watch_clr), 32'd0);
    chk("R13 idle epc", epc_o, m_epc);
    chk("R13 idle status", status_o, e_st);
    chk("R13 idle vector", redirect_pc, e_vec);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_kind = 0; req_sub = 0; req_pc = 0; req_in_ds = 0;
    status_i = 0; cause_i = 0; debug_i = 0; dm_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1
    chk("R1 status", status_o, 0);
    chk("R1 cause", cause_o, 0);
    chk("R1 epc", epc_o, 0);
    chk("R1 depc", depc_o, 0);
    chk("R1 redirect", 32'(redirect_valid), 0);
    chk("R1 random", 32'(random_o), N - 1);
    rst_n = 1;
    // move random away from reset value is impossible via ports; sweep
    for (int k = 0; k < 14; k++)
      for (int s = 0; s < 5; s++)
        for (int c = 0; c < 32; c++) begin
          logic [31:0] pc;
          pc = (k == 0 && c == 1) ? 32'h0 : 32'h0040_1000 + 32'(k * 4096 + s * 256 + c * 8);
          one_req(4'(k), (s == 4) ? 5'd21 : 5'(s), pc, c[0], c[1], c[2], c[3], c[4]);
        end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule